// File: doc/BRIEF.md
# Parallel Stuff-Code Sync Acquisition

This block hunts for frame alignment in a serial bit stream. Every bit time it shifts the incoming bit into an 11-bit window. It then compares the window against three fixed stuff command patterns at once: positive stuff, negative stuff and no action. The comparator taps at the odd bit positions below the top bit behave like inverted input lines. To offset this, the stored reference for those positions holds the complement of the nominal code bit, so a stream that carries the nominal code still produces a match.

A match sets a per-code compare latch, and the ORed latches raise the held sync indication at once. On the next bit clock a lock register takes over and freezes which code matched. On the bit clock after that, a single-bit-time sync pulse fires. A word-counter preset and an error-counter reset are issued alongside the pulse. While locked, the compare latches are held clear, so later matches change nothing. A synchronous clear returns the block to hunting.

Top module: `stuff_sync_acq`

## Requirements
- R1: After reset, sync_held, sync_pulse, word_preset, err_clr and code_sel are all zero.
- R2: Bits enter the window only on cycles where bit_en is high, and the first bit sent is code bit 10. A match occurs when the last eleven bits equal a nominal code. A stream that carries a code with bits 1, 3, 5, 7 and 9 flipped does not match.
- R3: sync_held rises on the bit_en edge that shifts in the final bit of a matching code. It then stays high until hunt_clr.
- R4: code_sel is one-hot: bit 0 is no action, bit 1 is positive stuff and bit 2 is negative stuff. It is zero while hunting. It is set on the first bit_en edge after the match.
- R5: sync_pulse rises on the second bit_en edge after the match. It falls on the following bit_en edge and fires only once per acquisition.
- R6: word_preset and err_clr are high exactly while sync_pulse is high.
- R7: Once locked, a later match on any code leaves code_sel unchanged and fires no further sync pulse.
- R8: hunt_clr clears sync_held, code_sel and sync_pulse on the next clock edge. After the clear, the block can acquire a code again.
- R9: If two codes match in the same bit time, code_sel picks no action first, then positive stuff, then negative stuff.
- R10: With bit_en high one clock in three, sync_pulse stays high for exactly three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hunt_clr | input | 1 | Synchronous clear back to hunting |
| bit_en | input | 1 | Bit-time strobe |
| bit_in | input | 1 | Serial data bit |
| sync_held | output | 1 | Parallel-sync indication |
| sync_pulse | output | 1 | One-bit-time sync pulse |
| word_preset | output | 1 | Preset for the external word counter |
| err_clr | output | 1 | Reset for the bit-error counters |
| code_sel | output | 3 | One-hot matched-code enable |

## Verification
The checker holds several rules on every cycle. code_sel never has more than one bit set, and it stays stable once locked. sync_held is sticky until a clear, and the pulse falls on the bit_en edge after it rises. The preset and reset appear only while locked, and a clear empties the state. Other behaviours can only be shown by the bench's scenarios: that each nominal code is recognised and an odd-bit-flipped one is not, the exact edge at which each output moves, the pulse width at a slower bit rate, and the priority choice. The priority case uses a second instance whose no-action and positive codes are equal.

// File: rtl/stuff_sync_acq.sv
module stuff_sync_acq #(
  parameter int          W       = 11,
  parameter logic [10:0] NA_CODE = 11'b10101100011,
  parameter logic [10:0] PS_CODE = 11'b11100010010,
  parameter logic [10:0] NS_CODE = 11'b00011101101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hunt_clr,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       sync_held,
  output logic       sync_pulse,
  output logic       word_preset,
  output logic       err_clr,
  output logic [2:0] code_sel
);
  localparam int NCODE = 3;

  function automatic logic [W-1:0] odd_mask();
    logic [W-1:0] m;
    m = '0;
    for (int i = 1; i < W - 1; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD_MASK = odd_mask();

  logic [W-1:0]     win_q;
  logic [W-1:0]     win_nx;
  logic [W-1:0]     tap_nx;
  logic [NCODE-1:0] hit;
  logic [NCODE-1:0] cmp_q;
  logic [NCODE-1:0] sel_q;
  logic [NCODE-1:0] sel_nx;
  logic             ps_q;
  logic             fired_q;
  logic             pulse_q;

  assign win_nx = {win_q[W-2:0], bit_in};
  assign tap_nx = win_nx ^ ODD_MASK;

  for (genvar g = 0; g < NCODE; g++) begin : g_cmp
    localparam logic [W-1:0] NOM = (g == 0) ? W'(NA_CODE) :
                                   (g == 1) ? W'(PS_CODE) : W'(NS_CODE);
    localparam logic [W-1:0] REF = NOM ^ ODD_MASK;
    assign hit[g] = (tap_nx == REF);
  end

  always_comb begin
    sel_nx = '0;
    if (cmp_q[0])      sel_nx[0] = 1'b1;
    else if (cmp_q[1]) sel_nx[1] = 1'b1;
    else if (cmp_q[2]) sel_nx[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (bit_en) win_q <= win_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cmp_q <= '0;
    else if (hunt_clr || ps_q) cmp_q <= '0;
    else if (bit_en)           cmp_q <= cmp_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= 1'b0;
      sel_q <= '0;
    end else if (hunt_clr) begin
      ps_q  <= 1'b0;
      sel_q <= '0;
    end else if (bit_en && !ps_q && |cmp_q) begin
      ps_q  <= 1'b1;
      sel_q <= sel_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (hunt_clr) begin
      pulse_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (bit_en) begin
      pulse_q <= ps_q && !fired_q;
      fired_q <= fired_q || ps_q;
    end
  end

  assign sync_held   = ps_q | (|cmp_q);
  assign sync_pulse  = pulse_q;
  assign word_preset = pulse_q;
  assign err_clr     = pulse_q;
  assign code_sel    = sel_q;
endmodule

module stuff_sync_acq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hunt_clr,
  input logic       bit_en,
  input logic       sync_held,
  input logic       sync_pulse,
  input logic       word_preset,
  input logic       err_clr,
  input logic [2:0] code_sel
);
  p_onehot_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code_sel));

  p_held_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_held && !hunt_clr) |=> sync_held);

  p_pulse_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && bit_en) |=> !sync_pulse);

  p_pulse_after_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pulse) |-> (code_sel != 3'b000));

  p_preset_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_preset || err_clr) |-> (sync_held && code_sel != 3'b000));

  p_sel_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_sel != 3'b000 && !hunt_clr) |=> $stable(code_sel));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_clr |=> (!sync_held && !sync_pulse && code_sel == 3'b000));
endmodule

bind stuff_sync_acq stuff_sync_acq_chk chk_i (.*);

// File: tb/stuff_sync_acq_tb.sv
`timescale 1ns/1ps
module stuff_sync_acq_tb_top;
  localparam logic [10:0] NA = 11'b10101100011;
  localparam logic [10:0] PS = 11'b11100010010;
  localparam logic [10:0] NS = 11'b00011101101;
  localparam logic [10:0] ODD = 11'b01010101010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hunt_clr = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic sync_held, sync_pulse, word_preset, err_clr;
  logic [2:0] code_sel;
  logic p_held, p_pulse, p_preset, p_err;
  logic [2:0] p_sel;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  stuff_sync_acq dut_i (
    .clk(clk), .rst_n(rst_n), .hunt_clr(hunt_clr), .bit_en(bit_en), .bit_in(bit_in),
    .sync_held(sync_held), .sync_pulse(sync_pulse), .word_preset(word_preset),
    .err_clr(err_clr), .code_sel(code_sel));

  stuff_sync_acq #(.NA_CODE(PS)) dut_prio_i (
    .clk(clk), .rst_n(rst_n), .hunt_clr(hunt_clr), .bit_en(bit_en), .bit_in(bit_in),
    .sync_held(p_held), .sync_pulse(p_pulse), .word_preset(p_preset),
    .err_clr(p_err), .code_sel(p_sel));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic b);
    bit_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic tick();
    bit_en = 1'b1; bit_in = 1'b0;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic clr();
    hunt_clr = 1'b1; bit_en = 1'b0;
    @(negedge clk);
    hunt_clr = 1'b0;
  endtask

  task automatic pad_and_clear();
    for (int i = 0; i < 12; i++) push(1'b0);
    clr();
  endtask

  task automatic send(input logic [10:0] c);
    for (int i = 10; i >= 0; i--) push(c[i]);
  endtask

  task automatic t_reset();
    chk("R1", "sync_held", sync_held, 0);
    chk("R1", "sync_pulse", sync_pulse, 0);
    chk("R1", "word_preset", word_preset, 0);
    chk("R1", "err_clr", err_clr, 0);
    chk("R1", "code_sel", code_sel, 0);
  endtask

  task automatic t_acquire(input logic [10:0] c, input logic [2:0] exp_sel);
    pad_and_clear();
    send(c);
    chk("R2", "sync_held after last bit", sync_held, 1);
    chk("R4", "code_sel before lock", code_sel, 0);
    tick();
    chk("R4", "code_sel locked", code_sel, exp_sel);
    chk("R5", "pulse early", sync_pulse, 0);
    tick();
    chk("R5", "pulse", sync_pulse, 1);
    chk("R6", "word_preset", word_preset, 1);
    chk("R6", "err_clr", err_clr, 1);
    tick();
    chk("R5", "pulse fall", sync_pulse, 0);
    chk("R6", "preset fall", word_preset, 0);
    chk("R3", "sync_held kept", sync_held, 1);
    for (int i = 0; i < 5; i++) tick();
    chk("R5", "no second pulse", sync_pulse, 0);
    chk("R3", "sync_held still", sync_held, 1);
  endtask

  task automatic t_flipped();
    pad_and_clear();
    send(PS ^ ODD);
    chk("R2", "flipped held", sync_held, 0);
    for (int i = 0; i < 3; i++) tick();
    chk("R2", "flipped sel", code_sel, 0);
    chk("R2", "flipped pulse", sync_pulse, 0);
  endtask

  task automatic t_locked_ignore();
    t_acquire(PS, 3'b010);
    send(NS);
    tick(); tick(); tick();
    chk("R7", "sel kept", code_sel, 3'b010);
    chk("R7", "no pulse", sync_pulse, 0);
  endtask

  task automatic t_clear_reacquire();
    clr();
    chk("R8", "held cleared", sync_held, 0);
    chk("R8", "sel cleared", code_sel, 0);
    chk("R8", "pulse cleared", sync_pulse, 0);
    t_acquire(NA, 3'b001);
  endtask

  task automatic t_slow();
    int hi;
    pad_and_clear();
    for (int i = 10; i >= 0; i--) begin
      push(PS[i]);
      @(negedge clk); @(negedge clk);
    end
    chk("R10", "held at slow rate", sync_held, 1);
    chk("R10", "sel not yet", code_sel, 0);
    hi = 0;
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 3; k++) begin
        bit_en = (k == 0); bit_in = 1'b0;
        @(negedge clk);
        if (sync_pulse) hi++;
      end
    end
    bit_en = 1'b0;
    chk("R10", "pulse clocks", hi, 3);
  endtask

  task automatic t_priority();
    pad_and_clear();
    send(PS);
    tick();
    chk("R9", "prio sel", p_sel, 3'b001);
    chk("R9", "main sel", code_sel, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_acquire(PS, 3'b010);
    t_acquire(NS, 3'b100);
    t_acquire(NA, 3'b001);
    t_flipped();
    t_locked_ignore();
    t_clear_reacquire();
    t_slow();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule